// File: doc/BRIEF.md
# PD Steering Motor Pulse Driver

This block closes the steering-wheel angle loop. It takes a commanded angle and a measured angle, both signed 16-bit values in tenths of a degree. It drives a stepper-style motor driver through two lines. A pulse train sets the rotation speed: a higher pulse rate turns the wheel faster. A separate direction line sets which way the wheel turns.

Once per fixed control period the block does three things:
- It forms the angle error and the change of that error since the last period.
- It weighs the two terms with signed fixed-point gains taken from input ports, giving a proportional-plus-derivative command.
- It loads the magnitude of that command, clamped to a hard ceiling, into a phase-accumulator pulse generator. The ceiling keeps the motor below its safe pulse rate.

The derivative term grows negative as a positive error shrinks, so it holds back the speed as the wheel nears its target. A zero error stops the pulses outright. The direction line never changes while a pulse is in flight.

Top module: `pd_steer_drive`

## Requirements
- R1: After reset, `pulse_o` and `dir_o` are 0. No pulse appears before the first control update.
- R2: A control update happens on every clock edge at which PERIOD_CYC further cycles have passed since reset was released. At that update the error is e = desired − actual, computed at 17 bits. The change of error is de = e − e_prev, where e_prev is the error from the previous update and is 0 after reset. The new rate takes effect from the next clock.
- R3: At an update with e > 0 the requested direction becomes 1 (positive rotation). With e < 0 it becomes 0. With e = 0 the request is held.
- R4: The command is (kp·e + kd·de) >>> GAIN_FRAC, an arithmetic shift. The gains are two's-complement values with GAIN_FRAC fraction bits. The rate increment is the magnitude of the command, clamped to INC_MAX.
- R5: An update with e = 0 sets the increment to 0, whatever de is.
- R6: `pulse_o` is the top bit of an ACC_W-bit accumulator that adds the increment on every clock. For an increment that is a power of two, the distance between rising edges is exactly 2^ACC_W / increment cycles, with a 50 % duty cycle.
- R7: While the increment is 0, the accumulator is cleared and `pulse_o` stays low.
- R8: `dir_o` takes the requested direction only in a cycle where `pulse_o` is low both before and after the edge. It never changes while a pulse is high, nor on the edge where a pulse rises.
- R9: In the first period after a step in error, the derivative term contributes to the rate. In later periods with a steady error, de = 0 and only the proportional term remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desired_i | input | ANG_W | Commanded angle, signed, 0.1 degree units |
| actual_i | input | ANG_W | Measured angle, signed, 0.1 degree units |
| kp_i | input | GAIN_W | Proportional gain, signed, GAIN_FRAC fraction bits |
| kd_i | input | GAIN_W | Derivative gain, signed, GAIN_FRAC fraction bits |
| pulse_o | output | 1 | Step pulse train to the motor driver |
| dir_o | output | 1 | Rotation direction, 1 = positive |

## Verification
The bench goes after the following corner cases:
- **Rate ceiling.** It drives a full-scale error of −65535 with the largest gain. A design whose clamp or product width was wrong would pulse far too fast, or at a wrapped, slow rate.
- **Gain sign.** It uses a negative proportional gain. A design that kept the command sign instead of its magnitude would stall.
- **Derivative term.** It steps the error and compares the first period with the settled one. A design that dropped de, or held a stale e_prev, would show the same rate in both.
- **Zero error with a large de.** A design that ignored this rule would keep pulsing.
- **Direction line.** A monitor watches every cycle for the direction changing while a pulse is high. A design that switched direction at the update would truncate a pulse at the driver.

// File: rtl/pd_steer_pkg.sv
package pd_steer_pkg;

   typedef enum logic {
      DIR_NEG = 1'b0,
      DIR_POS = 1'b1
   } dir_e;

endpackage

// File: rtl/pd_tick.sv
module pd_tick #(
   parameter int PERIOD_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R2: the counter never passes its terminal value
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/pd_law.sv
module pd_law
   import pd_steer_pkg::*;
#(
   parameter int ANG_W     = 16,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 4,
   parameter int INC_MAX   = 13,
   parameter int INC_W     = 4,
   parameter bit USE_D     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ANG_W-1:0]  desired_i,
   input  logic [ANG_W-1:0]  actual_i,
   input  logic [GAIN_W-1:0] kp_i,
   input  logic [GAIN_W-1:0] kd_i,
   output logic [INC_W-1:0]  inc_o,
   output dir_e              dir_o
);
   localparam int E_W = ANG_W + 1;
   localparam int D_W = ANG_W + 2;
   localparam int P_W = D_W + GAIN_W;
   localparam int S_W = P_W + 1;

   logic [E_W-1:0] err, err_q;
   logic [D_W-1:0] derr;
   logic signed [P_W-1:0] ex, dx, kpx, kdx, prod_p, prod_d;
   logic signed [S_W-1:0] sum, cmd;
   logic [S_W-1:0] mag;
   logic [INC_W-1:0] inc_sat;

   assign err  = {desired_i[ANG_W-1], desired_i} - {actual_i[ANG_W-1], actual_i};
   assign derr = {err[E_W-1], err} - {err_q[E_W-1], err_q};

   assign ex  = {{(P_W-E_W){err[E_W-1]}}, err};
   assign dx  = {{(P_W-D_W){derr[D_W-1]}}, derr};
   assign kpx = {{(P_W-GAIN_W){kp_i[GAIN_W-1]}}, kp_i};
   assign kdx = {{(P_W-GAIN_W){kd_i[GAIN_W-1]}}, kd_i};

   assign prod_p = ex * kpx;

   generate
      if (USE_D) begin : g_deriv
         assign prod_d = dx * kdx;
      end else begin : g_prop_only
         assign prod_d = '0;
      end
   endgenerate

   assign sum = {prod_p[P_W-1], prod_p} + {prod_d[P_W-1], prod_d};
   assign cmd = sum >>> GAIN_FRAC;
   assign mag = cmd[S_W-1] ? S_W'(-cmd) : S_W'(cmd);
   assign inc_sat = (mag > S_W'(INC_MAX)) ? INC_W'(INC_MAX) : mag[INC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= '0;
         inc_o <= '0;
         dir_o <= DIR_NEG;
      end else if (tick_i) begin
         err_q <= err;
         inc_o <= (|err) ? inc_sat : '0;
         if (|err) dir_o <= err[E_W-1] ? DIR_NEG : DIR_POS;
      end
   end

   a_r5_zero_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && (err == '0) |=> (inc_o == '0));
   a_r3_dir_pos: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !err[E_W-1] && (|err) |=> (dir_o == DIR_POS));
   a_r3_dir_neg: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && err[E_W-1] |=> (dir_o == DIR_NEG));
   a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(inc_o) && $stable(dir_o));
endmodule

// File: rtl/pd_nco.sv
module pd_nco
   import pd_steer_pkg::*;
#(
   parameter int ACC_W   = 16,
   parameter int INC_MAX = 13,
   parameter int INC_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc_i,
   input  dir_e             dir_req_i,
   output logic             pulse_o,
   output logic             dir_o
);
   logic [ACC_W-1:0] acc_q, acc_d, inc_x;

   assign inc_x   = {{(ACC_W-INC_W){1'b0}}, inc_i};
   assign acc_d   = (inc_i == '0) ? '0 : acc_q + inc_x;
   assign pulse_o = acc_q[ACC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         dir_o <= 1'b0;
      end else begin
         acc_q <= acc_d;
         if (!acc_q[ACC_W-1] && !acc_d[ACC_W-1]) dir_o <= dir_req_i;
      end
   end

   a_r4_inc_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i <= INC_W'(INC_MAX));
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i == '0) |=> !pulse_o);
   a_r8_dir_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dir_o) |-> !pulse_o && !$past(pulse_o));
endmodule

// File: rtl/pd_steer_drive.sv
module pd_steer_drive
   import pd_steer_pkg::*;
#(
   parameter int ANG_W      = 16,
   parameter int GAIN_W     = 8,
   parameter int GAIN_FRAC  = 4,
   parameter int ACC_W      = 16,
   parameter int INC_MAX    = 13,
   parameter int PERIOD_CYC = 100000,
   parameter bit USE_D      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ANG_W-1:0]  desired_i,
   input  logic [ANG_W-1:0]  actual_i,
   input  logic [GAIN_W-1:0] kp_i,
   input  logic [GAIN_W-1:0] kd_i,
   output logic              pulse_o,
   output logic              dir_o
);
   localparam int INC_W = $clog2(INC_MAX + 1);

   generate
      if (INC_MAX < 1 || INC_MAX >= 2 ** (ACC_W - 1)) begin : g_bad_ceiling
         $error("INC_MAX must lie in 1 .. 2**(ACC_W-1)-1");
      end
      if (PERIOD_CYC < 2) begin : g_bad_period
         $error("PERIOD_CYC must be at least 2");
      end
      if (GAIN_FRAC >= GAIN_W + ANG_W) begin : g_bad_frac
         $error("GAIN_FRAC too large for the product width");
      end
   endgenerate

   logic             tick;
   logic [INC_W-1:0] inc;
   dir_e             dir_req;

   pd_tick #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   pd_law #(
      .ANG_W(ANG_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
      .INC_MAX(INC_MAX), .INC_W(INC_W), .USE_D(USE_D)
   ) u_law (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .desired_i(desired_i), .actual_i(actual_i),
      .kp_i(kp_i), .kd_i(kd_i),
      .inc_o(inc), .dir_o(dir_req)
   );

   pd_nco #(.ACC_W(ACC_W), .INC_MAX(INC_MAX), .INC_W(INC_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .inc_i(inc), .dir_req_i(dir_req),
      .pulse_o(pulse_o), .dir_o(dir_o)
   );
endmodule

// File: tb/sim_pd_steer_drive.sv
module sim_pd_steer_drive;
   localparam int P   = 512;
   localparam int NV  = 9;
   // steady-state vectors: desired, actual, kp, kd (quarter units), expected period, dir
   localparam int VD[NV]   = '{16, 0, 100, 5, -32768, 40, 8, 16, 0};
   localparam int VA[NV]   = '{0, 32, -900, -3, 32767, 40, 0, 0, 0};
   localparam int VKP[NV]  = '{4, 4, 4, 8, 127, 4, 16, -4, 4};
   localparam int VKD[NV]  = '{0, -2, 0, 0, 0, 0, 0, 0, 0};
   localparam int VPER[NV] = '{64, 32, 16, 64, 16, 0, 32, 64, 0};
   localparam int VDIR[NV] = '{1, 0, 1, 1, 0, 0, 1, 1, 1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] desired = 16'd16, actual = 16'd0;
   logic [7:0] kp = 8'd4, kd = 8'd0;
   logic pulse, dir;
   int cyc = 0, total = 0, bad = 0, viol = 0;
   logic pdir = 1'b0, ppulse = 1'b0, done = 1'b0;

   pd_steer_drive #(.GAIN_FRAC(2), .ACC_W(10), .INC_MAX(64), .PERIOD_CYC(P)) u0 (
      .clk(clk), .rst_n(rst_n), .desired_i(desired), .actual_i(actual),
      .kp_i(kp), .kd_i(kd), .pulse_o(pulse), .dir_o(dir)
   );

   always #5 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // R8 monitor: direction must not move around a high pulse
   always @(negedge clk) begin
      if (rst_n && (dir !== pdir) && (pulse || ppulse)) viol++;
      pdir <= dir;
      ppulse <= pulse;
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_to(input int ph);
      do @(negedge clk); while ((cyc % P) != ph);
   endtask

   task automatic measure(output int per, output int hi, output int stray);
      logic prev, found;
      per = 0; hi = 0; stray = 0; found = 1'b0; prev = pulse;
      for (int t = 0; t < 300 && !found; t++) begin
         @(negedge clk);
         if (pulse && !prev) found = 1'b1;
         else if (pulse) stray++;
         prev = pulse;
      end
      if (found) begin
         logic fin;
         fin = 1'b0; hi = 1;
         for (int t = 0; t < 200 && !fin; t++) begin
            @(negedge clk);
            per++;
            if (pulse && !prev) fin = 1'b1;
            else if (pulse) hi++;
            prev = pulse;
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=0", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int per, hi, stray;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulse after reset", int'(pulse), 0);
      chk("R1 dir after reset", int'(dir), 0);
      wait_to(100);
      measure(per, hi, stray);
      chk("R1 no pulse before first update", per, 0);
      chk("R1 line low before first update", stray, 0);

      for (int i = 0; i < NV; i++) begin
         wait_to(256);
         desired = 16'(VD[i]); actual = 16'(VA[i]);
         kp = 8'(VKP[i]); kd = 8'(VKD[i]);
         wait_to(0);
         wait_to(0);
         wait_to(100);
         measure(per, hi, stray);
         chk($sformatf("R4 R6 period vec%0d", i), per, VPER[i]);
         chk($sformatf("R3 dir vec%0d", i), int'(dir), VDIR[i]);
         if (VPER[i] > 0) chk($sformatf("R6 duty vec%0d", i), hi, VPER[i] / 2);
         else chk($sformatf("R5 R7 idle low vec%0d", i), stray, 0);
      end

      // R9: step with derivative gain, first period vs settled period
      wait_to(256);
      desired = 16'd32; actual = 16'd0; kp = 8'd4; kd = 8'hFE;
      wait_to(0);
      wait_to(100);
      measure(per, hi, stray);
      chk("R9 first period uses de", per, 64);
      wait_to(0);
      wait_to(100);
      measure(per, hi, stray);
      chk("R9 settled period", per, 32);

      // R5: zero error with large de stops pulses at once
      wait_to(256);
      desired = 16'd0;
      wait_to(0);
      wait_to(100);
      measure(per, hi, stray);
      chk("R5 zero error no pulse", per, 0);
      chk("R7 line low when idle", stray, 0);
      chk("R3 dir held on zero error", int'(dir), 1);

      chk("R8 dir only at pulse boundary", viol, 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule